// File: doc/BRIEF.md
# Masked Interrupt Aggregation Controller

This block collects level-sensitive, active-high interrupt requests from a parameterised number of functional-unit sources. It drives four interrupt lines to a host processor. Each line has two programmable masks over the same set of sources:

- An any-of mask fires the line as soon as any source it enables is high.
- An all-of mask fires the line only while every source it enables is high.

The line is the logical OR of the two terms. An all-of mask left empty never fires the line.

Sources are synchronised through two flops before any masking, and the four lines are registered. A line rises three clock edges after the qualifying source change and falls again by itself when the condition goes away, so nothing has to be cleared. When a line fires, the host reads a status word holding the synchronised level of every source to find the cause.

Registers are reached through a plain single-beat 32-bit port: one read or one write per cycle, with no pipelining. Read data is registered.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all four lines are low, every mask register reads zero and the read data is zero.
- R2: Any-of term. With the any-of mask of line i at word address 1+i, a mask bit of 1 enables that source. The line goes high while at least one enabled source is high.
- R3: All-of term. With the all-of mask of line i at word address 5+i, a mask bit of 1 enables that source. The line goes high only while every enabled source is high, and stays low if any enabled source is low.
- R4: An all-of mask of all zeros contributes 0 to its line, whatever the source levels are.
- R5: Each line is the OR of its any-of term and its all-of term.
- R6: A source change written before a clock edge reaches the lines at the third rising edge and not earlier. A line falls on its own once its qualifying sources drop.
- R7: Reading word address 0 returns the synchronised source levels in bits [NUM_SRC-1:0], zero above them. Any read result appears on the data output after the edge that samples the read strobe, and holds until the next read.
- R8: A write updates only the addressed mask register, and that register reads back the written low NUM_SRC bits.
- R9: Writes to word address 0 or to an unmapped address change no register. Reads of unmapped addresses return zero.
- R10: The four lines are independent: masks programmed for one line never raise another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIrq | input | NUM_SRC | Raw level interrupt requests from the sources |
| regAddr | input | ADDR_W | Word address of the register access |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe, one cycle per read |
| rdData | output | 32 | Registered read data |
| irqLine | output | 4 | Master interrupt lines to the host |

## Verification
The hardest situation to reach from the ports is a line held up by both terms at once, where dropping one source must leave the other term still firing. The stimulus programs overlapping any-of and all-of masks on the same line and walks the sources through patterns that satisfy one term, both terms, or neither. Every outcome is sampled exactly three edges after the source change, so that the synchroniser latency is checked as well. A second directed pass aims writes at the status word and at unmapped addresses, then reads every mask back to show that nothing moved.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int LINES    = 4;
  localparam int STAT_IDX = 0;
  localparam int ANY_BASE = 1;
  localparam int ALL_BASE = ANY_BASE + LINES;
  localparam int REG_CNT  = ALL_BASE + LINES;

  typedef struct packed {
    logic [LINES-1:0] anyWr;
    logic [LINES-1:0] allWr;
    logic             rdEn;
    logic             rdStat;
    logic [LINES-1:0] rdAny;
    logic [LINES-1:0] rdAll;
  } aggStrobes_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  output aggStrobes_t       strobes
);
  always_comb begin
    strobes        = '0;
    strobes.rdEn   = rdEn;
    strobes.rdStat = rdEn && (int'(regAddr) == STAT_IDX);
    for (int i = 0; i < LINES; i++) begin
      strobes.anyWr[i] = wrEn && (int'(regAddr) == ANY_BASE + i);
      strobes.allWr[i] = wrEn && (int'(regAddr) == ALL_BASE + i);
      strobes.rdAny[i] = rdEn && (int'(regAddr) == ANY_BASE + i);
      strobes.rdAll[i] = rdEn && (int'(regAddr) == ALL_BASE + i);
    end
  end

  initial begin
    if (REG_CNT > (1 << ADDR_W)) $error("ADDR_W too small for register map");
  end
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  logic [NUM_SRC-1:0] wrBits,
  input  aggStrobes_t        strobes,
  output logic [31:0]        rdData,
  output logic [LINES-1:0]   irqLine
);
  logic [NUM_SRC-1:0] syncMeta, syncLvl;
  logic [NUM_SRC-1:0] anyMask [LINES];
  logic [NUM_SRC-1:0] allMask [LINES];
  logic [LINES-1:0]   lineNext;
  logic [NUM_SRC-1:0] rdSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta <= '0;
      syncLvl  <= '0;
    end else begin
      syncMeta <= srcIrq;
      syncLvl  <= syncMeta;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic anyHit, allHit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        anyMask[g] <= '0;
        allMask[g] <= '0;
      end else begin
        if (strobes.anyWr[g]) anyMask[g] <= wrBits;
        if (strobes.allWr[g]) allMask[g] <= wrBits;
      end
    end

    assign anyHit      = |(syncLvl & anyMask[g]);
    assign allHit      = (allMask[g] != '0) && ((syncLvl & allMask[g]) == allMask[g]);
    assign lineNext[g] = anyHit | allHit;

    p_idle_line_r2: assert property (@(posedge clk) disable iff (!rstN)
      (anyMask[g] == '0 && allMask[g] == '0) |=> !irqLine[g]);
    p_any_fires_r2: assert property (@(posedge clk) disable iff (!rstN)
      ((syncLvl & anyMask[g]) != '0) |=> irqLine[g]);
    p_all_fires_r3: assert property (@(posedge clk) disable iff (!rstN)
      (allMask[g] != '0 && (syncLvl & allMask[g]) == allMask[g]) |=> irqLine[g]);
    p_empty_all_r4: assert property (@(posedge clk) disable iff (!rstN)
      (allMask[g] == '0 && (syncLvl & anyMask[g]) == '0) |=> !irqLine[g]);
    p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.anyWr[g] && !strobes.allWr[g]) |=>
        ($stable(anyMask[g]) && $stable(allMask[g])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqLine <= '0;
    else       irqLine <= lineNext;
  end

  always_comb begin
    rdSel = strobes.rdStat ? syncLvl : '0;
    for (int i = 0; i < LINES; i++) begin
      if (strobes.rdAny[i]) rdSel = rdSel | anyMask[i];
      if (strobes.rdAll[i]) rdSel = rdSel | allMask[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strobes.rdEn) rdData <= 32'(rdSel);
  end

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdEn |=> $stable(rdData));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  input  logic               rdEn,
  output logic [31:0]        rdData,
  output logic [LINES-1:0]   irqLine
);
  aggStrobes_t strobes;

  irq_agg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .strobes (strobes)
  );

  irq_agg_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcIrq  (srcIrq),
    .wrBits  (wrData[NUM_SRC-1:0]),
    .strobes (strobes),
    .rdData  (rdData),
    .irqLine (irqLine)
  );

  initial begin
    if (NUM_SRC < 1 || NUM_SRC > 32) $error("NUM_SRC must be 1..32");
  end
endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  localparam int NSRC = 8;
  localparam int NVEC = 14;
  // packed {anyMask[24:17], allMask[16:9], src[8:1], expectedLine[0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 8'hFF, 1'b0},
    {8'h01, 8'h00, 8'h01, 1'b1},
    {8'h01, 8'h00, 8'hFE, 1'b0},
    {8'hF0, 8'h00, 8'h10, 1'b1},
    {8'h00, 8'h0F, 8'h0F, 1'b1},
    {8'h00, 8'h0F, 8'h07, 1'b0},
    {8'h00, 8'h0F, 8'hFF, 1'b1},
    {8'h00, 8'h00, 8'h00, 1'b0},
    {8'h00, 8'h81, 8'h81, 1'b1},
    {8'h00, 8'h81, 8'h80, 1'b0},
    {8'h10, 8'h0C, 8'h10, 1'b1},
    {8'h10, 8'h0C, 8'h0C, 1'b1},
    {8'h10, 8'h0C, 8'h04, 1'b0},
    {8'hFF, 8'hFF, 8'h00, 1'b0}
  };

  logic            clk = 0;
  logic            rstN = 0;
  logic [NSRC-1:0] srcIrq = '0;
  logic [3:0]      regAddr = '0;
  logic            wrEn = 0;
  logic [31:0]     wrData = '0;
  logic            rdEn = 0;
  logic [31:0]     rdData;
  logic [3:0]      irqLine;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_aggregator #(.NUM_SRC(NSRC), .ADDR_W(4)) u_irq_aggregator (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .regAddr(regAddr),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .irqLine(irqLine)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    regAddr = 4'(addr); wrData = data; wrEn = 1;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic regRead(input int addr, output logic [31:0] data);
    @(negedge clk);
    regAddr = 4'(addr); rdEn = 1;
    @(negedge clk);
    rdEn = 0;
    data = rdData;
  endtask

  task automatic setSrc(input logic [NSRC-1:0] v);
    @(negedge clk);
    srcIrq = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 lines", 32'(irqLine), 32'h0);
    check("R1 rdData", rdData, 32'h0);
    for (int a = 1; a < 9; a++) begin
      regRead(a, rd);
      check("R1 mask", rd, 32'h0);
    end

    // R2 R3 R4 R5 table on line 0
    for (int v = 0; v < NVEC; v++) begin
      regWrite(1, 32'(VEC[v][24:17]));
      regWrite(5, 32'(VEC[v][16:9]));
      setSrc(VEC[v][8:1]);
      check($sformatf("R2/R3/R4/R5 vec%0d", v), 32'(irqLine), {31'b0, VEC[v][0]});
    end

    // R6 latency and self-clearing
    regWrite(1, 32'h02);
    regWrite(5, 32'h00);
    setSrc(8'h00);
    @(negedge clk); srcIrq = 8'h02;
    @(negedge clk); check("R6 edge1", 32'(irqLine[0]), 32'h0);
    @(negedge clk); check("R6 edge2", 32'(irqLine[0]), 32'h0);
    @(negedge clk); check("R6 edge3", 32'(irqLine[0]), 32'h1);
    srcIrq = 8'h00;
    @(negedge clk); @(negedge clk);
    check("R6 still high", 32'(irqLine[0]), 32'h1);
    @(negedge clk);
    check("R6 self clear", 32'(irqLine[0]), 32'h0);

    // R7 status read and hold
    setSrc(8'hA5);
    regRead(0, rd);
    check("R7 status", rd, 32'h000000A5);
    srcIrq = 8'h3C;
    repeat (4) @(negedge clk);
    check("R7 hold", rdData, 32'h000000A5);
    regRead(0, rd);
    check("R7 status2", rd, 32'h0000003C);

    // R8 single-register write and readback
    regWrite(1, 32'h0);
    regWrite(3, 32'hFFFF_FF5A);
    regWrite(7, 32'h0000_00C3);
    regRead(3, rd); check("R8 any2", rd, 32'h5A);
    regRead(7, rd); check("R8 all2", rd, 32'hC3);
    regRead(2, rd); check("R8 any1 untouched", rd, 32'h0);
    regRead(6, rd); check("R8 all1 untouched", rd, 32'h0);

    // R9 ignored writes and unmapped reads
    regWrite(0, 32'hFF);
    regWrite(15, 32'hFF);
    regWrite(9, 32'hFF);
    for (int a = 1; a < 9; a++) begin
      regRead(a, rd);
      check("R9 masks kept", rd, (a == 3) ? 32'h5A : (a == 7) ? 32'hC3 : 32'h0);
    end
    regRead(15, rd); check("R9 unmapped read", rd, 32'h0);
    setSrc(8'h00);
    check("R9 no line", 32'(irqLine), 32'h0);

    // R10 line independence
    regWrite(3, 32'h0);
    regWrite(7, 32'h0);
    regWrite(4, 32'h08);
    setSrc(8'h08);
    check("R10 only line3", 32'(irqLine), 32'h8);
    regWrite(8, 32'h06);
    setSrc(8'h06);
    check("R10 all-of line3", 32'(irqLine), 32'h8);
    setSrc(8'h02);
    check("R10 none", 32'(irqLine), 32'h0);

    finished = 1;
    summary();
  end
endmodule